// File: doc/BRIEF.md
# Coprocessor Mailbox Register Responder

This block is the coprocessor-side register window through which a host hands commands to a small management processor. The host sees a control register that holds the coprocessor in reset or stops its clock, a doorbell it rings to announce a command, a status mailbox it polls for the outcome, and a five-word message area where commands and answers are exchanged.

In place of real firmware, a built-in responder acts as the coprocessor. It runs when the doorbell holds a nonzero value and the control register lets the coprocessor run. It takes the command, clears the doorbell and checks the message. It then writes a complete answer message back into the message area and only then posts a status code. The answer's data word comes from three input ports: a version word and two pointer words. A pointer whose top nibble names neither the message area (1) nor the data memory (0) raises a one-cycle fault flag.

A message is five 32-bit words, held at these indices: 0 header, 1 command, 2 argument count, 3 argument, 4 checksum. The checksum is the wrapping 32-bit sum of words 0 to 3.

Top module: `mbox_responder`

## Requirements
- R1: After reset the control register reads 0x5 (held and clock stopped), and the doorbell, the status mailbox and every message word read 0.
- R2: Byte offsets: control 0x000, doorbell 0x010, status 0x014, message word i at 0x100 + 4*i for i in 0..4. Control keeps only bit 0 (hold) and bit 2 (clock stop), and its other bits read 0. The doorbell and message words store all 32 bits. Any other offset reads 0. Read data and its valid flag appear in the cycle after the read request.
- R3: The responder takes a command only while the doorbell is nonzero and control bits 0 and 2 are both clear. Taking a command clears the doorbell.
- R4: A command message has header 1 and argument count 1. Command 1 with argument 1 answers with the version word. Command 2 with argument 1 answers with the refresh pointer. Command 2 with argument 2 answers with the vendor pointer. The status is 1. The answer is header 2, the command echoed, count 1, the selected word, and a correct checksum.
- R5: Error codes, highest priority first: header not 1 gives 0x80000001; checksum mismatch gives 0x80000004; argument count not 1 gives 0x80000008; any other command/argument pair gives 0x80000002. The answer still carries header 2, the echoed command, count 1, data word 0 and a correct checksum.
- R6: The status mailbox stays 0 while a command is processed. It turns nonzero only after all five answer words are in the message area.
- R7: Any host write to the status mailbox clears it to 0, whatever the data.
- R8: Host writes to the message area are ignored from the cycle a command is taken until its status is posted.
- R9: A host doorbell write in the same cycle that the responder takes a command wins. The written value stays in the doorbell and starts another command once the first one finishes.
- R10: Setting control bit 0 or bit 2 while a command is in progress abandons it. No status is posted and the responder returns to idle.
- R11: The fault flag pulses for one cycle, together with a success status, when a refresh or vendor answer carries a pointer whose bits [31:28] are neither 0 nor 1. The version word never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| info_word | input | 32 | Version word returned for the info command |
| refresh_ptr | input | 32 | Pointer returned for the refresh command |
| vendor_ptr | input | 32 | Pointer returned for the vendor command |
| ptr_fault | output | 1 | One-cycle pulse for an answer pointer with an invalid memory space |

## Verification
The doorbell has two writers that can act in the same cycle: the host ringing it, and the responder clearing it as it takes a command. The bench provokes the collision by holding the coprocessor, ringing the doorbell, then releasing control and writing a new doorbell value on the next edge. That edge is exactly the one where the command is taken. The collision is judged by reading back the new value while the first command is running. A second command must then follow, and it must fail on the answer header left in the message area. The same timing is used to land a message-area write in the middle of processing and to withdraw the run permission during a command.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MSG_WORDS = 5;
  localparam int IDX_W     = $clog2(MSG_WORDS);

  localparam int F_HDR  = 0;
  localparam int F_CMD  = 1;
  localparam int F_ARGC = 2;
  localparam int F_ARG0 = 3;
  localparam int F_SUM  = 4;

  localparam int OFF_CTRL = 'h000;
  localparam int OFF_DB   = 'h010;
  localparam int OFF_STAT = 'h014;
  localparam int OFF_RAM  = 'h100;

  typedef logic [31:0] word_t;
  typedef logic [MSG_WORDS-1:0][31:0] msg_t;

  localparam word_t HDR_CMD      = 32'd1;
  localparam word_t HDR_RSP      = 32'd2;
  localparam word_t ST_OK        = 32'h0000_0001;
  localparam word_t ST_BAD_HDR   = 32'h8000_0001;
  localparam word_t ST_UNKNOWN   = 32'h8000_0002;
  localparam word_t ST_BAD_SUM   = 32'h8000_0004;
  localparam word_t ST_MALFORMED = 32'h8000_0008;

  typedef enum logic [1:0] {OP_INFO, OP_REFRESH, OP_VENDOR, OP_NONE} op_e;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WRITE, S_POST} state_e;

  function automatic word_t msg_sum(msg_t m);
    word_t s;
    s = '0;
    for (int i = 0; i < MSG_WORDS - 1; i++) s = s + m[i];
    return s;
  endfunction

  function automatic op_e decode_op(msg_t m);
    if (m[F_CMD] == 32'd1 && m[F_ARG0] == 32'd1) return OP_INFO;
    if (m[F_CMD] == 32'd2 && m[F_ARG0] == 32'd1) return OP_REFRESH;
    if (m[F_CMD] == 32'd2 && m[F_ARG0] == 32'd2) return OP_VENDOR;
    return OP_NONE;
  endfunction

  function automatic word_t judge(msg_t m);
    if (m[F_HDR] != HDR_CMD)        return ST_BAD_HDR;
    if (m[F_SUM] != msg_sum(m))     return ST_BAD_SUM;
    if (m[F_ARGC] != 32'd1)         return ST_MALFORMED;
    if (decode_op(m) == OP_NONE)    return ST_UNKNOWN;
    return ST_OK;
  endfunction

  function automatic logic space_bad(word_t p);
    return p[31:28] > 4'd1;
  endfunction

  function automatic msg_t build_rsp(word_t cmd, word_t arg0);
    msg_t m;
    m = '0;
    m[F_HDR]  = HDR_RSP;
    m[F_CMD]  = cmd;
    m[F_ARGC] = 32'd1;
    m[F_ARG0] = arg0;
    m[F_SUM]  = msg_sum(m);
    return m;
  endfunction

endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [AW-1:0]    host_addr,
  input  word_t            host_wdata,
  output word_t            host_rdata,
  output logic             host_rvalid,
  input  logic             busy,
  input  logic             db_clr,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  word_t            eng_wdata,
  input  logic             stat_we,
  input  word_t            stat_wdata,
  output logic             run,
  output word_t            doorbell,
  output word_t            status,
  output msg_t             ram,
  output logic             host_db_wr,
  output logic             host_stat_wr,
  output logic             host_ram_wr
);

  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_DB   = AW'(OFF_DB);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_RAM  = AW'(OFF_RAM);
  localparam logic [AW-1:0] RAM_SPAN = AW'(4 * MSG_WORDS);

  logic             hold_q, gate_q;
  word_t            db_q, stat_q, rdata_q, rd_next;
  logic             rvalid_q;
  word_t            ram_q [MSG_WORDS];
  logic [AW-1:0]    ram_off;
  logic             ram_hit;
  logic [IDX_W-1:0] ram_idx;
  logic             host_ctrl_wr;

  assign ram_off      = host_addr - A_RAM;
  assign ram_hit      = (host_addr >= A_RAM) && (ram_off < RAM_SPAN) && (ram_off[1:0] == 2'b00);
  assign ram_idx      = ram_off[IDX_W+1:2];
  assign host_ctrl_wr = host_we && (host_addr == A_CTRL);
  assign host_db_wr   = host_we && (host_addr == A_DB);
  assign host_stat_wr = host_we && (host_addr == A_STAT);
  assign host_ram_wr  = host_we && ram_hit;

  assign run      = !hold_q && !gate_q;
  assign doorbell = db_q;
  assign status   = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      gate_q <= 1'b1;
    end else if (host_ctrl_wr) begin
      hold_q <= host_wdata[0];
      gate_q <= host_wdata[2];
    end
  end

  // Host doorbell write takes precedence over the responder's clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          db_q <= '0;
    else if (host_db_wr) db_q <= host_wdata;
    else if (db_clr)     db_q <= '0;
  end

  // Responder post takes precedence over a host acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stat_q <= '0;
    else if (stat_we)      stat_q <= stat_wdata;
    else if (host_stat_wr) stat_q <= '0;
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ram_q[g] <= '0;
      else if (eng_we && eng_idx == IDX_W'(g))
        ram_q[g] <= eng_wdata;
      else if (host_ram_wr && !busy && ram_idx == IDX_W'(g))
        ram_q[g] <= host_wdata;
    end
    assign ram[g] = ram_q[g];
  end

  always_comb begin
    rd_next = '0;
    if (host_addr == A_CTRL)      rd_next = {29'b0, gate_q, 1'b0, hold_q};
    else if (host_addr == A_DB)   rd_next = db_q;
    else if (host_addr == A_STAT) rd_next = stat_q;
    else if (ram_hit)             rd_next = ram_q[ram_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_re;
      if (host_re) rdata_q <= rd_next;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

endmodule

// File: rtl/mbox_engine.sv
module mbox_engine
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  word_t            doorbell,
  input  msg_t             ram,
  input  word_t            info_word,
  input  word_t            refresh_ptr,
  input  word_t            vendor_ptr,
  output logic             take,
  output logic             busy,
  output logic             eng_we,
  output logic [IDX_W-1:0] eng_idx,
  output word_t            eng_wdata,
  output logic             stat_we,
  output word_t            stat_wdata,
  output logic             ptr_fault
);

  state_e           st_q;
  msg_t             req_q, rsp_q;
  word_t            code_q, code_n, arg0_n;
  logic             fault_q, ptr_fault_q;
  logic [IDX_W-1:0] idx_q;
  op_e              op;

  always_comb begin
    op     = decode_op(req_q);
    code_n = judge(req_q);
    case (op)
      OP_INFO:    arg0_n = info_word;
      OP_REFRESH: arg0_n = refresh_ptr;
      OP_VENDOR:  arg0_n = vendor_ptr;
      default:    arg0_n = '0;
    endcase
    if (code_n != ST_OK) arg0_n = '0;
  end

  assign take       = (st_q == S_IDLE) && run && (doorbell != '0);
  assign busy       = take || (st_q != S_IDLE);
  assign eng_we     = (st_q == S_WRITE) && run;
  assign eng_idx    = idx_q;
  assign eng_wdata  = rsp_q[idx_q];
  assign stat_we    = (st_q == S_POST) && run;
  assign stat_wdata = code_q;
  assign ptr_fault  = ptr_fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      req_q       <= '0;
      rsp_q       <= '0;
      code_q      <= '0;
      fault_q     <= 1'b0;
      ptr_fault_q <= 1'b0;
      idx_q       <= '0;
    end else begin
      ptr_fault_q <= stat_we && fault_q;
      if (!run && st_q != S_IDLE) begin
        st_q <= S_IDLE;
      end else begin
        case (st_q)
          S_IDLE: if (take) begin
            req_q <= ram;
            st_q  <= S_EVAL;
          end
          S_EVAL: begin
            rsp_q   <= build_rsp(req_q[F_CMD], arg0_n);
            code_q  <= code_n;
            fault_q <= (code_n == ST_OK) && (op != OP_INFO) && space_bad(arg0_n);
            idx_q   <= '0;
            st_q    <= S_WRITE;
          end
          S_WRITE: begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(MSG_WORDS - 1)) st_q <= S_POST;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic [31:0]   info_word,
  input  logic [31:0]   refresh_ptr,
  input  logic [31:0]   vendor_ptr,
  output logic          ptr_fault
);

  logic             run, busy, take;
  logic             eng_we, stat_we;
  logic [IDX_W-1:0] eng_idx;
  word_t            eng_wdata, stat_wdata, doorbell, status;
  msg_t             ram;
  logic             host_db_wr, host_stat_wr, host_ram_wr;

  mbox_regfile #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (bus_valid && bus_write),
    .host_re      (bus_valid && !bus_write),
    .host_addr    (bus_addr),
    .host_wdata   (bus_wdata),
    .host_rdata   (bus_rdata),
    .host_rvalid  (bus_rvalid),
    .busy         (busy),
    .db_clr       (take),
    .eng_we       (eng_we),
    .eng_idx      (eng_idx),
    .eng_wdata    (eng_wdata),
    .stat_we      (stat_we),
    .stat_wdata   (stat_wdata),
    .run          (run),
    .doorbell     (doorbell),
    .status       (status),
    .ram          (ram),
    .host_db_wr   (host_db_wr),
    .host_stat_wr (host_stat_wr),
    .host_ram_wr  (host_ram_wr)
  );

  mbox_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .doorbell    (doorbell),
    .ram         (ram),
    .info_word   (info_word),
    .refresh_ptr (refresh_ptr),
    .vendor_ptr  (vendor_ptr),
    .take        (take),
    .busy        (busy),
    .eng_we      (eng_we),
    .eng_idx     (eng_idx),
    .eng_wdata   (eng_wdata),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .ptr_fault   (ptr_fault)
  );

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
  import mbox_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  run,
  input logic  busy,
  input logic  take,
  input logic  stat_we,
  input logic  eng_we,
  input logic  host_db_wr,
  input logic  host_stat_wr,
  input logic  host_ram_wr,
  input logic  ptr_fault,
  input word_t host_wdata,
  input word_t doorbell,
  input word_t status,
  input msg_t  ram
);

  AST_TAKE_CLEARS_DB: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !host_db_wr) |=> (doorbell == '0)); // R3

  AST_POST_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (ram[F_HDR] == HDR_RSP && ram[F_SUM] == msg_sum(ram))); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_wr && !stat_we) |=> (status == '0)); // R7

  AST_RAM_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ram_wr && busy && !eng_we) |=> $stable(ram)); // R8

  AST_HOST_DB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_db_wr |=> (doorbell == $past(host_wdata))); // R9

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (run || !busy)); // R10

  AST_FAULT_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_fault |-> (status == ST_OK)); // R11

endmodule

bind mbox_responder mbox_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .busy         (busy),
  .take         (take),
  .stat_we      (stat_we),
  .eng_we       (eng_we),
  .host_db_wr   (host_db_wr),
  .host_stat_wr (host_stat_wr),
  .host_ram_wr  (host_ram_wr),
  .ptr_fault    (ptr_fault),
  .host_wdata   (bus_wdata),
  .doorbell     (doorbell),
  .status       (status),
  .ram          (ram)
);

// File: tb/mbox_responder_tb.sv
`timescale 1ns/1ps
module mbox_responder_tb;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_DB   = 12'h010;
  localparam logic [11:0] A_STAT = 12'h014;
  localparam logic [11:0] A_RAM  = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bv = 1'b0, bw = 1'b0;
  logic [11:0] ba = '0;
  logic [31:0] bd = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [31:0] info_w = 32'hF102_0304;
  logic [31:0] refr_p = 32'h1000_0040;
  logic [31:0] vend_p = 32'h0000_0200;
  logic        fault;

  int n_cmp = 0, n_bad = 0, fault_cnt = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mbox_responder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_wdata(bd), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .info_word(info_w), .refresh_ptr(refr_p), .vendor_ptr(vend_p), .ptr_fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("SB unexpected read", rdata, 32'hxxxx_xxxx);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (t != "") chk(t, rdata, e);
      end
    end
    if (rst_n && fault) fault_cnt++;
  end

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bv = 1; bw = 1; ba = a; bd = d;
    @(negedge clk);
    bv = 0; bw = 0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bv = 1; bw = 0; ba = a;
    @(negedge clk);
    bv = 0;
  endtask

  task automatic rd_now(input logic [11:0] a, output logic [31:0] v);
    exp_q.push_back('0); tag_q.push_back("");
    bv = 1; bw = 0; ba = a;
    @(negedge clk);
    bv = 0;
    #1 v = rdata;
    @(negedge clk);
  endtask

  task automatic poll_for(input logic [31:0] want, output logic [31:0] v);
    v = '0;
    for (int i = 0; i < 60; i++) begin
      rd_now(A_STAT, v);
      if (v == want) break;
    end
  endtask

  task automatic poll_nonzero(output logic [31:0] v);
    v = '0;
    for (int i = 0; i < 60; i++) begin
      rd_now(A_STAT, v);
      if (v != 0) break;
    end
  endtask

  task automatic load_msg(input logic [31:0] h, input logic [31:0] c, input logic [31:0] n,
                          input logic [31:0] a, input logic [31:0] sum_adj);
    wr(A_RAM + 12'h0, h);
    wr(A_RAM + 12'h4, c);
    wr(A_RAM + 12'h8, n);
    wr(A_RAM + 12'hC, a);
    wr(A_RAM + 12'h10, h + c + n + a + sum_adj);
  endtask

  task automatic expect_rsp(input logic [31:0] c, input logic [31:0] a0, input string tag);
    rd_exp(A_RAM + 12'h0, 32'd2, {tag, " rsp header"});
    rd_exp(A_RAM + 12'h4, c, {tag, " rsp command"});
    rd_exp(A_RAM + 12'h8, 32'd1, {tag, " rsp count"});
    rd_exp(A_RAM + 12'hC, a0, {tag, " rsp data"});
    rd_exp(A_RAM + 12'h10, 32'd3 + c + a0, {tag, " rsp checksum"});
  endtask

  task automatic run_cmd(input logic [31:0] h, input logic [31:0] c, input logic [31:0] n,
                         input logic [31:0] a, input logic [31:0] sum_adj,
                         input logic [31:0] exp_st, input logic [31:0] exp_a0, input string tag);
    logic [31:0] v;
    load_msg(h, c, n, a, sum_adj);
    wr(A_DB, 32'd1);
    rd_exp(A_STAT, 32'd0, {tag, " R6 status quiet while busy"});
    poll_nonzero(v);
    chk({tag, " status"}, v, exp_st);
    expect_rsp(c, exp_a0, {tag, " R6"});
    rd_exp(A_DB, 32'd0, {tag, " R3 doorbell cleared"});
    wr(A_STAT, 32'h1234_5678);
    rd_exp(A_STAT, 32'd0, {tag, " R7 ack clears status"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_exp(A_CTRL, 32'h5, "R1 control");
    rd_exp(A_DB, 32'h0, "R1 doorbell");
    rd_exp(A_STAT, 32'h0, "R1 status");
    rd_exp(A_RAM + 12'h8, 32'h0, "R1 message word");

    // R2 register map
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_exp(A_CTRL, 32'h5, "R2 control keeps bits 0 and 2");
    wr(A_DB, 32'hA5A5_0003);
    rd_exp(A_DB, 32'hA5A5_0003, "R2 doorbell");
    wr(12'h020, 32'hFFFF_FFFF);
    rd_exp(12'h020, 32'h0, "R2 unmapped");
    wr(A_RAM + 12'hC, 32'hDEAD_BEEF);
    rd_exp(A_RAM + 12'hC, 32'hDEAD_BEEF, "R2 message word 3");
    rd_exp(A_RAM + 12'h14, 32'h0, "R2 past message area");

    // R3 gating by control bits
    repeat (20) @(negedge clk);
    rd_exp(A_DB, 32'hA5A5_0003, "R3 held: doorbell kept");
    wr(A_CTRL, 32'h1);
    repeat (15) @(negedge clk);
    rd_exp(A_DB, 32'hA5A5_0003, "R3 bit0 set: doorbell kept");
    wr(A_CTRL, 32'h4);
    repeat (15) @(negedge clk);
    rd_exp(A_DB, 32'hA5A5_0003, "R3 bit2 set: doorbell kept");
    rd_exp(A_STAT, 32'h0, "R3 no status while stopped");
    wr(A_CTRL, 32'h0);
    poll_nonzero(v);
    chk("R3 R5 zero header runs as bad header", v, 32'h8000_0001);
    rd_exp(A_DB, 32'h0, "R3 doorbell cleared on take");
    wr(A_STAT, 32'h0);

    // R4 valid commands
    run_cmd(1, 1, 1, 1, 0, 32'h1, info_w, "R4 info");
    run_cmd(1, 2, 1, 1, 0, 32'h1, refr_p, "R4 refresh");
    run_cmd(1, 2, 1, 2, 0, 32'h1, vend_p, "R4 vendor");
    chk("R11 no fault for space 0/1 or version word", fault_cnt, 0);

    // R5 errors and priority
    run_cmd(3, 1, 1, 1, 0, 32'h8000_0001, 0, "R5 bad header");
    run_cmd(1, 1, 1, 1, 1, 32'h8000_0004, 0, "R5 bad checksum");
    run_cmd(1, 1, 2, 1, 0, 32'h8000_0008, 0, "R5 malformed count");
    run_cmd(1, 2, 1, 3, 0, 32'h8000_0002, 0, "R5 unknown argument");
    run_cmd(1, 7, 1, 1, 0, 32'h8000_0002, 0, "R5 unknown command");
    run_cmd(5, 1, 1, 1, 9, 32'h8000_0001, 0, "R5 header beats checksum");
    run_cmd(1, 1, 0, 1, 4, 32'h8000_0004, 0, "R5 checksum beats count");
    run_cmd(1, 7, 0, 1, 0, 32'h8000_0008, 0, "R5 count beats unknown");

    // R11 invalid pointer space
    refr_p = 32'h3000_0040;
    fault_cnt = 0;
    run_cmd(1, 2, 1, 1, 0, 32'h1, 32'h3000_0040, "R11 bad space");
    chk("R11 one fault pulse", fault_cnt, 1);
    refr_p = 32'h1000_0040;

    // R8 message write during processing is dropped
    load_msg(1, 1, 1, 1, 0);
    wr(A_DB, 32'd1);
    repeat (4) @(negedge clk);
    wr(A_RAM + 12'h0, 32'h5555_5555);
    poll_nonzero(v);
    chk("R8 status", v, 32'h1);
    rd_exp(A_RAM + 12'h0, 32'd2, "R8 busy write ignored");
    wr(A_STAT, 32'h0);

    // R10 abandon on hold
    load_msg(1, 1, 1, 1, 0);
    wr(A_DB, 32'd1);
    wr(A_CTRL, 32'h1);
    repeat (20) @(negedge clk);
    rd_exp(A_STAT, 32'h0, "R10 no status after abandon");
    rd_exp(A_DB, 32'h0, "R10 doorbell was taken");
    wr(A_CTRL, 32'h0);
    repeat (20) @(negedge clk);
    rd_exp(A_STAT, 32'h0, "R10 nothing resumes");

    // R9 host doorbell write collides with take
    wr(A_CTRL, 32'h5);
    load_msg(1, 1, 1, 1, 0);
    wr(A_DB, 32'd1);
    wr(A_CTRL, 32'h0);
    wr(A_DB, 32'd7);
    rd_exp(A_DB, 32'd7, "R9 host doorbell value kept");
    poll_nonzero(v);
    chk("R9 first command status", v, 32'h1);
    poll_for(32'h8000_0001, v);
    chk("R9 second command runs on answer header", v, 32'h8000_0001);
    rd_exp(A_DB, 32'h0, "R9 doorbell cleared by second take");
    wr(A_STAT, 32'h0);

    repeat (5) @(negedge clk);
    chk("SB queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule